// File: doc/BRIEF.md
# I2C Data Packing Buffer

This block sits between a 16-bit host data register and the byte-serial transfer engine of an I2C controller. It holds up to four bytes and serves one direction at a time. On the transmit side the host loads two bytes per access, or one byte for an odd-length message, and the engine removes them oldest first. On the receive side the engine appends bytes and the host removes them two at a time. A byte-order input selects which half of the host word carries the older byte.

The buffer is built around a three-state controller. **EMPTY** holds nothing. **TX** holds bytes loaded by the host. **RX** holds bytes pushed by the engine. An accepted host write moves EMPTY to TX. The pop that removes the last byte moves TX back to EMPTY. A push moves EMPTY to RX. A host read that removes the last byte moves RX back to EMPTY. No other transitions exist.

Every effect on the controller's status register is reported as a one-cycle pulse, one cycle after the access that caused it. Examples are clearing a ready flag or marking a lone byte. If several strobes arrive in the same cycle, only one is served, in this priority: host write, host read, pop, push.

Top module: `i2c_pack_buf`

## Requirements
- R1: After reset both counts are 0, `tx_avail` is 0, `rx_room` is 1 and every status pulse is 0.
- R2: A 16-bit write to an EMPTY or TX buffer holding at most 2 bytes adds 2 bytes and raises `tx_count` by 2. With `swap_order`=1 the byte in `wr_data[15:8]` is sent before `wr_data[7:0]`. With `swap_order`=0 the order is reversed.
- R3: An 8-bit write (`wr_byte`=1) under the same condition adds `wr_data[7:0]` as one byte, sent after all bytes already held.
- R4: A write is ignored, leaving counts unchanged and producing no pulse, when more than 2 transmit bytes are held or while receive bytes are held.
- R5: Every accepted write pulses `st_clr_underflow`. It also pulses `st_clr_tx_ready` when the buffer then holds more than 2 bytes.
- R6: In TX, `tx_pop` takes one byte, and `tx_data` shows the oldest byte held during that cycle. `tx_avail` is 1 exactly in TX, and a pop outside TX is ignored.
- R7: A push in EMPTY or RX with fewer than 4 bytes held appends `rx_data`. `rx_room` is 1 exactly when a push would be taken. A push is ignored in TX or with 4 bytes held.
- R8: During a read in RX, `rd_data` holds the two oldest bytes. The oldest byte is in `rd_data[15:8]` when `swap_order`=1 and in `rd_data[7:0]` when it is 0. A missing second byte reads as zero.
- R9: A read in RX with one byte held pulses `st_set_single` and empties the buffer. With two or more bytes held, the read removes two bytes.
- R10: A read that empties the buffer pulses `st_clr_rx_ready`. If `mst_rx` is 1 at that point, it also pulses `st_set_access_rdy` and `st_clr_master`.
- R11: Every served read pulses `st_clr_overrun`. A read outside RX returns zero and changes no count.
- R12: A cycle with no strobe changes no count and produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| swap_order | input | 1 | Byte-order select for host accesses |
| mst_rx | input | 1 | Controller is currently a master receiver |
| wr_en | input | 1 | Host write strobe |
| wr_byte | input | 1 | 1: 8-bit write, 0: 16-bit write |
| wr_data | input | 16 | Host write data |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 16 | Host read data, valid in the cycle of `rd_en` |
| tx_pop | input | 1 | Engine takes one transmit byte |
| tx_data | output | 8 | Oldest transmit byte |
| tx_avail | output | 1 | Transmit bytes are held |
| rx_push | input | 1 | Engine delivers one received byte |
| rx_data | input | 8 | Received byte |
| rx_room | output | 1 | A push would be accepted |
| tx_count | output | 3 | Transmit bytes held |
| rx_count | output | 3 | Receive bytes held |
| st_clr_underflow | output | 1 | Pulse: clear transmit underflow flag |
| st_clr_tx_ready | output | 1 | Pulse: clear transmit ready flag |
| st_set_single | output | 1 | Pulse: set single-byte flag |
| st_clr_rx_ready | output | 1 | Pulse: clear receive ready flag |
| st_set_access_rdy | output | 1 | Pulse: set access ready flag |
| st_clr_master | output | 1 | Pulse: clear master mode |
| st_clr_overrun | output | 1 | Pulse: clear receive overrun flag |

## Verification
Several properties are checked on every cycle by the assertions:
- the fill level stays bounded;
- EMPTY is entered exactly when the count is zero;
- idle cycles and rejected writes hold the count;
- every single-byte pulse traces back to a read of a lone byte;
- the access-ready pulse always travels with the receive-ready and master pulses.

Byte ordering, on the other hand, can only be shown by the bench's scenarios compared against its queue model. This covers transmit order after mixed 8-bit and 16-bit writes, and the lane placement in read data for both byte orders. The same applies to the zero fill of a missing second byte and to the exact count after a read that shifts the store.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;

    typedef enum logic [1:0] {
        PB_EMPTY = 2'd0,
        PB_TX    = 2'd1,
        PB_RX    = 2'd2
    } pb_state_e;

    // storage operations requested by the controller for one cycle
    typedef struct packed {
        logic ld16;      // shift in two bytes from the host
        logic ld8;       // shift in one byte from the host
        logic drop16;    // shift out two bytes after a read
        logic push;      // place a received byte above the held ones
        logic push_clr;  // clear the store before the first received byte
    } pb_op_s;

endpackage

// File: rtl/pbuf_lane_swap.sv
module pbuf_lane_swap #(
    parameter int BW = 8
) (
    input  logic            en,
    input  logic [2*BW-1:0] din,
    output logic [2*BW-1:0] dout
);
    always_comb begin
        if (en) dout = {din[BW-1:0], din[2*BW-1:BW]};
        else    dout = din;
    end
endmodule

// File: rtl/pbuf_ctrl.sv
module pbuf_ctrl
    import pbuf_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_byte,
    input  logic          rd_en,
    input  logic          tx_pop,
    input  logic          rx_push,
    input  logic          mst_rx,
    output pb_state_e     state,
    output logic [CW-1:0] cnt,
    output pb_op_s        op,
    output logic          st_clr_underflow,
    output logic          st_clr_tx_ready,
    output logic          st_set_single,
    output logic          st_clr_rx_ready,
    output logic          st_set_access_rdy,
    output logic          st_clr_master,
    output logic          st_clr_overrun
);
    localparam logic [CW-1:0] ONE    = CW'(1);
    localparam logic [CW-1:0] TWO    = CW'(2);
    localparam logic [CW-1:0] WR_LIM = CW'(DEPTH - 2);
    localparam logic [CW-1:0] FULL   = CW'(DEPTH);

    pb_state_e     state_nx;
    logic [CW-1:0] cnt_nx;
    logic nx_und, nx_txr, nx_sgl, nx_rxr, nx_ard, nx_mst, nx_ovr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PB_EMPTY;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // transitions and storage requests
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        op       = '0;
        nx_und = 1'b0; nx_txr = 1'b0; nx_sgl = 1'b0; nx_rxr = 1'b0;
        nx_ard = 1'b0; nx_mst = 1'b0; nx_ovr = 1'b0;
        unique case (state)
            PB_EMPTY, PB_TX: begin
                if (wr_en) begin
                    if (cnt <= WR_LIM) begin
                        op.ld16  = !wr_byte;
                        op.ld8   = wr_byte;
                        cnt_nx   = cnt + (wr_byte ? ONE : TWO);
                        state_nx = PB_TX;
                        nx_und   = 1'b1;
                        nx_txr   = (cnt_nx > TWO);
                    end
                end else if (rd_en) begin
                    nx_ovr = 1'b1;
                end else if (tx_pop && state == PB_TX) begin
                    cnt_nx = cnt - ONE;
                    if (cnt == ONE) state_nx = PB_EMPTY;
                end else if (rx_push && state == PB_EMPTY) begin
                    op.push     = 1'b1;
                    op.push_clr = 1'b1;
                    cnt_nx      = ONE;
                    state_nx    = PB_RX;
                end
            end
            PB_RX: begin
                if (wr_en) begin
                    // write ignored while receive bytes are held
                end else if (rd_en) begin
                    nx_ovr = 1'b1;
                    if (cnt == ONE) begin
                        nx_sgl = 1'b1;
                        cnt_nx = '0;
                    end else if (cnt == TWO) begin
                        cnt_nx = '0;
                    end else begin
                        op.drop16 = 1'b1;
                        cnt_nx    = cnt - TWO;
                    end
                    if (cnt_nx == '0) begin
                        state_nx = PB_EMPTY;
                        nx_rxr   = 1'b1;
                        nx_ard   = mst_rx;
                        nx_mst   = mst_rx;
                    end
                end else if (tx_pop) begin
                    // pop ignored while receiving
                end else if (rx_push && cnt < FULL) begin
                    op.push = 1'b1;
                    cnt_nx  = cnt + ONE;
                end
            end
            default: state_nx = PB_EMPTY;
        endcase
    end

    // status pulse outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_clr_underflow  <= 1'b0;
            st_clr_tx_ready   <= 1'b0;
            st_set_single     <= 1'b0;
            st_clr_rx_ready   <= 1'b0;
            st_set_access_rdy <= 1'b0;
            st_clr_master     <= 1'b0;
            st_clr_overrun    <= 1'b0;
        end else begin
            st_clr_underflow  <= nx_und;
            st_clr_tx_ready   <= nx_txr;
            st_set_single     <= nx_sgl;
            st_clr_rx_ready   <= nx_rxr;
            st_set_access_rdy <= nx_ard;
            st_clr_master     <= nx_mst;
            st_clr_overrun    <= nx_ovr;
        end
    end

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL);

    // R1
    empty_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PB_EMPTY) == (cnt == '0));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !rd_en && !tx_pop && !rx_push) |=> ($stable(cnt) && $stable(state)));

    // R4
    wr_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (state == PB_RX || cnt > WR_LIM)) |=> ($stable(cnt) && !st_clr_underflow));

    // R9
    single_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_set_single |-> $past(rd_en && !wr_en && state == PB_RX && cnt == ONE));

    // R10
    access_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_set_access_rdy |-> (st_clr_rx_ready && st_clr_master));

    // R11
    overrun_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en) |=> st_clr_overrun);
endmodule

// File: rtl/i2c_pack_buf.sv
module i2c_pack_buf
    import pbuf_pkg::*;
#(
    parameter int BW    = 8,
    parameter int DEPTH = 4,
    parameter int HW    = 2 * BW,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          swap_order,
    input  logic          mst_rx,
    input  logic          wr_en,
    input  logic          wr_byte,
    input  logic [HW-1:0] wr_data,
    input  logic          rd_en,
    output logic [HW-1:0] rd_data,
    input  logic          tx_pop,
    output logic [BW-1:0] tx_data,
    output logic          tx_avail,
    input  logic          rx_push,
    input  logic [BW-1:0] rx_data,
    output logic          rx_room,
    output logic [CW-1:0] tx_count,
    output logic [CW-1:0] rx_count,
    output logic          st_clr_underflow,
    output logic          st_clr_tx_ready,
    output logic          st_set_single,
    output logic          st_clr_rx_ready,
    output logic          st_set_access_rdy,
    output logic          st_clr_master,
    output logic          st_clr_overrun
);
    localparam int            IW   = $clog2(DEPTH);
    localparam logic [CW-1:0] ONE  = CW'(1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    pb_state_e     state;
    logic [CW-1:0] cnt;
    pb_op_s        op;
    logic [DEPTH-1:0][BW-1:0] store, store_nx;
    logic [HW-1:0] wr_lanes, rd_lanes;

    pbuf_ctrl #(.DEPTH(DEPTH), .CW(CW)) i_ctrl (
        .clk               (clk),
        .rst_n             (rst_n),
        .wr_en             (wr_en),
        .wr_byte           (wr_byte),
        .rd_en             (rd_en),
        .tx_pop            (tx_pop),
        .rx_push           (rx_push),
        .mst_rx            (mst_rx),
        .state             (state),
        .cnt               (cnt),
        .op                (op),
        .st_clr_underflow  (st_clr_underflow),
        .st_clr_tx_ready   (st_clr_tx_ready),
        .st_set_single     (st_set_single),
        .st_clr_rx_ready   (st_clr_rx_ready),
        .st_set_access_rdy (st_set_access_rdy),
        .st_clr_master     (st_clr_master),
        .st_clr_overrun    (st_clr_overrun)
    );

    // host word to store lanes: swap_order=1 keeps the high byte in lane 1
    pbuf_lane_swap #(.BW(BW)) i_wr_swap (
        .en   (!swap_order),
        .din  (wr_data),
        .dout (wr_lanes)
    );

    // lanes 1:0 of the store to host word
    pbuf_lane_swap #(.BW(BW)) i_rd_swap (
        .en   (swap_order),
        .din  ({store[1], store[0]}),
        .dout (rd_lanes)
    );

    always_comb begin
        store_nx = store;
        if (op.ld16) begin
            store_nx = {store[DEPTH-3:0], wr_lanes};
        end else if (op.ld8) begin
            store_nx = {store[DEPTH-2:0], wr_data[BW-1:0]};
        end else if (op.drop16) begin
            store_nx = {{HW{1'b0}}, store[DEPTH-1:2]};
        end else if (op.push) begin
            if (op.push_clr) store_nx = '0;
            store_nx[IW'(cnt)] = rx_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) store <= '0;
        else        store <= store_nx;
    end

    assign tx_data  = store[IW'(cnt - ONE)];
    assign rd_data  = (state == PB_RX) ? rd_lanes : '0;
    assign tx_avail = (state == PB_TX);
    assign rx_room  = (state != PB_TX) && (cnt < FULL);
    assign tx_count = (state == PB_TX) ? cnt : '0;
    assign rx_count = (state == PB_RX) ? cnt : '0;
endmodule

// File: tb/test_i2c_pack_buf.sv
`timescale 1ns/1ps
module test_i2c_pack_buf;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        swap_order = 1'b0, mst_rx = 1'b0;
    logic        wr_en = 1'b0, wr_byte = 1'b0, rd_en = 1'b0, tx_pop = 1'b0, rx_push = 1'b0;
    logic [15:0] wr_data = '0;
    logic [7:0]  rx_data = '0;
    logic [15:0] rd_data;
    logic [7:0]  tx_data;
    logic        tx_avail, rx_room;
    logic [2:0]  tx_count, rx_count;
    logic        s_und, s_txr, s_sgl, s_rxr, s_ard, s_mst, s_ovr;

    int checks = 0;
    int errors = 0;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];

    always #10 clk = ~clk;

    i2c_pack_buf i_i2c_pack_buf (
        .clk(clk), .rst_n(rst_n), .swap_order(swap_order), .mst_rx(mst_rx),
        .wr_en(wr_en), .wr_byte(wr_byte), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data),
        .tx_pop(tx_pop), .tx_data(tx_data), .tx_avail(tx_avail),
        .rx_push(rx_push), .rx_data(rx_data), .rx_room(rx_room),
        .tx_count(tx_count), .rx_count(rx_count),
        .st_clr_underflow(s_und), .st_clr_tx_ready(s_txr), .st_set_single(s_sgl),
        .st_clr_rx_ready(s_rxr), .st_set_access_rdy(s_ard), .st_clr_master(s_mst),
        .st_clr_overrun(s_ovr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] exp_rd();
        logic [7:0] b0, b1;
        if (rxq.size() == 0) return 16'h0;
        b0 = rxq[0];
        b1 = (rxq.size() > 1) ? rxq[1] : 8'h00;
        return swap_order ? {b0, b1} : {b1, b0};
    endfunction

    // one clock of stimulus, entered and left just after a falling edge
    task automatic cyc(input bit w, input bit wb, input logic [15:0] wd,
                       input bit r, input bit p, input bit pu, input logic [7:0] pd);
        string tag;
        bit e_und = 0, e_txr = 0, e_sgl = 0, e_rxr = 0, e_ard = 0, e_mst = 0, e_ovr = 0;
        wr_en = w; wr_byte = wb; wr_data = wd; rd_en = r; tx_pop = p; rx_push = pu; rx_data = pd;
        #1;
        if (r && !w) chk("R8 rd_data", rd_data, exp_rd());
        if (p && !w && !r && txq.size() > 0) chk("R6 tx_data", tx_data, txq[0]);
        if (w) begin
            if (rxq.size() == 0 && txq.size() <= 2) begin
                if (wb) txq.push_back(wd[7:0]);
                else if (swap_order) begin txq.push_back(wd[15:8]); txq.push_back(wd[7:0]); end
                else begin txq.push_back(wd[7:0]); txq.push_back(wd[15:8]); end
                e_und = 1; e_txr = (txq.size() > 2);
                tag = wb ? "R3" : "R2";
            end else tag = "R4";
        end else if (r) begin
            e_ovr = 1; tag = "R11";
            if (rxq.size() > 0) begin
                tag = "R9";
                if (rxq.size() == 1) begin e_sgl = 1; void'(rxq.pop_front()); end
                else begin void'(rxq.pop_front()); void'(rxq.pop_front()); end
                if (rxq.size() == 0) begin e_rxr = 1; e_ard = mst_rx; e_mst = mst_rx; end
            end
        end else if (p) begin
            tag = "R6";
            if (txq.size() > 0) void'(txq.pop_front());
        end else if (pu) begin
            tag = "R7";
            if (txq.size() == 0 && rxq.size() < 4) rxq.push_back(pd);
        end else tag = "R12";
        @(posedge clk); #1;
        wr_en = 0; rd_en = 0; tx_pop = 0; rx_push = 0;
        chk({tag, " tx_count"}, tx_count, txq.size());
        chk({tag, " rx_count"}, rx_count, rxq.size());
        chk("R6 tx_avail", tx_avail, txq.size() > 0);
        chk("R7 rx_room", rx_room, txq.size() == 0 && rxq.size() < 4);
        chk("R5 underflow pulse", s_und, e_und);
        chk("R5 tx ready pulse", s_txr, e_txr);
        chk("R9 single pulse", s_sgl, e_sgl);
        chk("R10 rx ready pulse", s_rxr, e_rxr);
        chk("R10 access ready pulse", s_ard, e_ard);
        chk("R10 master pulse", s_mst, e_mst);
        chk("R11 overrun pulse", s_ovr, e_ovr);
        @(negedge clk);
    endtask

    task automatic wr16(input logic [15:0] d); cyc(1, 0, d, 0, 0, 0, 8'h0); endtask
    task automatic wr8(input logic [7:0] d);   cyc(1, 1, {8'h0, d}, 0, 0, 0, 8'h0); endtask
    task automatic rd();                       cyc(0, 0, 16'h0, 1, 0, 0, 8'h0); endtask
    task automatic pop();                      cyc(0, 0, 16'h0, 0, 1, 0, 8'h0); endtask
    task automatic push(input logic [7:0] d);  cyc(0, 0, 16'h0, 0, 0, 1, d); endtask
    task automatic idle();                     cyc(0, 0, 16'h0, 0, 0, 0, 8'h0); endtask

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 tx_count", tx_count, 0);
        chk("R1 rx_count", rx_count, 0);
        chk("R1 tx_avail", tx_avail, 0);
        chk("R1 rx_room", rx_room, 1);
        chk("R1 pulses", {s_und, s_txr, s_sgl, s_rxr, s_ard, s_mst, s_ovr}, 0);

        // R2 R3 R4 R5 R6: low byte first, odd tail, rejects, empty pop
        swap_order = 0;
        wr16(16'h1234); wr8(8'h56); wr16(16'hABCD); wr8(8'hEF);
        push(8'h77); rd();
        pop(); pop(); pop(); pop(); idle();

        // R2 R3: high byte first, refill after a pop
        swap_order = 1;
        wr8(8'h11); wr16(16'h2233); pop(); wr8(8'h44);
        pop(); pop(); pop();

        // R7 R8 R10: full receive, ignored push/write/pop, master receiver end
        swap_order = 0; mst_rx = 1;
        push(8'hA1); push(8'hA2); push(8'hA3); push(8'hA4); push(8'hA5);
        wr16(16'h5555); pop(); rd(); rd();

        // R8 R9 R11: shifted read, single-byte read, empty read
        swap_order = 1; mst_rx = 0;
        push(8'hB1); push(8'hB2); push(8'hB3); rd(); push(8'hB4); rd();
        push(8'hC1); rd(); rd(); idle();

        // mixed sequences in both byte orders
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            swap_order = i[6];
            mst_rx = lfsr[9];
            case (lfsr[2:0])
                3'd0, 3'd1: wr16(lfsr ^ 16'h5A3C);
                3'd2:       wr8(lfsr[15:8]);
                3'd3:       rd();
                3'd4, 3'd5: pop();
                3'd6:       push(lfsr[11:4]);
                default:    if (lfsr[3]) push(lfsr[7:0]); else rd();
            endcase
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule